// File: doc/BRIEF.md
# 1-Wire ROM Command Controller

This block is the identity layer of a 1-Wire slave. A bit-level physical layer beneath it turns bus waveforms into simple strobes. One strobe marks a finished reset/presence exchange, one delivers each bit the master writes, and one requests the bit for each read slot. The controller answers each read request with the bit to drive: 0 pulls the bus low and 1 releases it. After a bus reset it takes an 8-bit command and then runs the identity exchange that command selects. On success it raises a grant that opens the memory command layer above it.

The 64-bit identity has three parts. The low byte is a family code, the next 48 bits are a serial number, and the top byte is a CRC-8 over the lower 56 bits. The family code and the serial number are parameters. The CRC byte is not stored as a constant. A serial CRC generator shifts the 56 parameter bits once after power-on reset and keeps the result. A search variant lets only a device with an unacknowledged interrupt take part, so a master can find the devices that need service.

Top module: `owrom_slave`

## Requirements
- R1: The identity CRC byte (identity bits 63..56) equals the CRC-8 with polynomial x^8+x^5+x^4+1. The register starts at zero and is fed identity bits 0..55 one at a time, bit 0 first. Feeding all 64 identity bits through the same CRC gives zero.
- R2: After a bus reset the controller takes 8 command bits on master write slots, least significant bit first. The accepted codes are 33h (read), 55h (match), F0h (search), CCh (skip) and ECh (conditional search). Any other code drops the device out: it gives no grant and releases the bus until the next bus reset.
- R3: Read (33h) returns identity bits 0..63 in order on 64 read slots. The grant rises after the 64th slot.
- R4: Match (55h) compares 64 master write bits with identity bits 0..63. If all 64 agree, the grant rises. On the first disagreement the device drops out.
- R5: Search (F0h) repeats three slots for each identity bit i = 0..63. The first read slot returns bit i, the second read slot returns its complement, and then a master write slot arrives. A written bit equal to bit i moves on to the next bit, and the grant rises after bit 63. An unequal bit drops the device out.
- R6: Conditional search (ECh) behaves as R5 when irq_pending_i is 1 at the eighth command bit. Otherwise the device drops out at once.
- R7: Skip (CCh) raises the grant at the clock edge that takes the eighth command bit, with no identity exchange.
- R8: Read slots return 1 while the device waits for a command, is dropped out, is granted, or is not yet initialised.
- R9: A bus reset strobe in any state after initialisation clears the grant on the next clock edge and restarts command reception. The grant stays high until such a strobe.
- R10: After rst_ni is released, the controller spends 56 clock cycles building the CRC. During that time the grant is 0, read slots return 1, and bus reset strobes are ignored.
- R11: After initialisation no command is accepted until the first bus reset strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle strobe: bus reset and presence exchange done |
| wr_valid_i | input | 1 | One-cycle strobe: a master write slot finished |
| wr_bit_i | input | 1 | Bit received in that write slot |
| rd_req_i | input | 1 | One-cycle strobe: a read slot is being served |
| irq_pending_i | input | 1 | An interrupt is pending and has not been acknowledged |
| rd_bit_o | output | 1 | Bit to drive in the current read slot (0 pulls low, 1 releases) |
| grant_o | output | 1 | Memory command layer enabled |

## Verification
The bench builds the block with family code 04h and the serial number 48'h5A_C3_17_E2_90_6B. This serial mixes runs of ones and zeros, so the computed CRC byte is nonzero. A search with a wrong choice therefore hits both 0 and 1 identity bits across its random drop-out positions. Match and search are each run once with no flipped bit and several times with a single flipped bit at a random position, including bit 0 and bit 63. The conditional search is run with the interrupt input both high and low.

// File: rtl/owrom_pkg.sv
package owrom_pkg;
  localparam int ID_W   = 64;
  localparam int BASE_W = 56;
  localparam int IDX_W  = $clog2(ID_W);

  localparam logic [7:0] CMD_READ  = 8'h33;
  localparam logic [7:0] CMD_MATCH = 8'h55;
  localparam logic [7:0] CMD_SRCH  = 8'hF0;
  localparam logic [7:0] CMD_SKIP  = 8'hCC;
  localparam logic [7:0] CMD_CSRCH = 8'hEC;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SRCH, ST_GRANT, ST_DROP
  } state_t;

  typedef enum logic [1:0] {PH_TRUE, PH_COMP, PH_WRITE} phase_t;
endpackage

// File: rtl/owrom_crc8.sv
module owrom_crc8 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;
  logic       fb;

  // reflected x^8+x^5+x^4+1, LSB first
  assign fb = crc_q[0] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= {1'b0, crc_q[7:1]} ^ (fb ? 8'h8C : 8'h00);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/owrom_idsrc.sv
module owrom_idsrc
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h04,
  parameter logic [47:0] SERIAL = 48'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o,
  output logic             ready_o
);
  localparam logic [BASE_W-1:0] BASE = {SERIAL, FAMILY};

  logic [IDX_W-1:0] init_cnt;
  logic             ready_q;
  logic [7:0]       crc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_cnt <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q) begin
      if (init_cnt == IDX_W'(BASE_W - 1)) ready_q <= 1'b1;
      else                                init_cnt <= init_cnt + 1'b1;
    end
  end

  owrom_crc8 u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!ready_q),
    .bit_i (BASE[init_cnt]),
    .crc_o (crc)
  );

  // bits 56..63 map onto crc[0..7] via the low index bits
  assign bit_o   = (idx_i < IDX_W'(BASE_W)) ? BASE[idx_i] : crc[idx_i[2:0]];
  assign ready_o = ready_q;
endmodule

// File: rtl/owrom_fsm.sv
module owrom_fsm
  import owrom_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             bus_reset_i,
  input  logic             wr_valid_i,
  input  logic             wr_bit_i,
  input  logic             rd_req_i,
  input  logic             irq_pending_i,
  input  logic             id_bit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_bit_o,
  output logic             grant_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

  state_t           state_q;
  phase_t           ph_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       cmd_q;
  logic [7:0]       cmd_nxt;

  assign cmd_nxt = {wr_bit_i, cmd_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      ph_q    <= PH_TRUE;
      idx_q   <= '0;
      cmd_q   <= '0;
    end else if (state_q == ST_INIT) begin
      if (ready_i) state_q <= ST_IDLE;
    end else if (bus_reset_i) begin
      state_q <= ST_CMD;
      ph_q    <= PH_TRUE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_CMD: if (wr_valid_i) begin
          cmd_q <= cmd_nxt[7:1];
          if (idx_q == IDX_W'(7)) begin
            idx_q <= '0;
            case (cmd_nxt)
              CMD_READ:  state_q <= ST_READ;
              CMD_MATCH: state_q <= ST_MATCH;
              CMD_SRCH:  state_q <= ST_SRCH;
              CMD_SKIP:  state_q <= ST_GRANT;
              CMD_CSRCH: state_q <= irq_pending_i ? ST_SRCH : ST_DROP;
              default:   state_q <= ST_DROP;
            endcase
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_READ: if (rd_req_i) begin
          if (idx_q == LAST) state_q <= ST_GRANT;
          else               idx_q   <= idx_q + 1'b1;
        end
        ST_MATCH: if (wr_valid_i) begin
          if (wr_bit_i != id_bit_i) state_q <= ST_DROP;
          else if (idx_q == LAST)   state_q <= ST_GRANT;
          else                      idx_q   <= idx_q + 1'b1;
        end
        ST_SRCH: begin
          case (ph_q)
            PH_TRUE: if (rd_req_i) ph_q <= PH_COMP;
            PH_COMP: if (rd_req_i) ph_q <= PH_WRITE;
            default: if (wr_valid_i) begin
              ph_q <= PH_TRUE;
              if (wr_bit_i != id_bit_i) state_q <= ST_DROP;
              else if (idx_q == LAST)   state_q <= ST_GRANT;
              else                      idx_q   <= idx_q + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_bit_o = 1'b1;
    if (state_q == ST_READ) rd_bit_o = id_bit_i;
    else if (state_q == ST_SRCH && ph_q == PH_TRUE) rd_bit_o = id_bit_i;
    else if (state_q == ST_SRCH && ph_q == PH_COMP) rd_bit_o = !id_bit_i;
  end

  assign grant_o = (state_q == ST_GRANT);
  assign idx_o   = idx_q;
endmodule

// File: rtl/owrom_slave.sv
module owrom_slave
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h04,
  parameter logic [47:0] SERIAL = 48'h0000_0000_0001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic wr_valid_i,
  input  logic wr_bit_i,
  input  logic rd_req_i,
  input  logic irq_pending_i,
  output logic rd_bit_o,
  output logic grant_o
);
  logic [IDX_W-1:0] idx;
  logic             id_bit;
  logic             id_ready;

  owrom_idsrc #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .bit_o  (id_bit),
    .ready_o(id_ready)
  );

  owrom_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ready_i      (id_ready),
    .bus_reset_i  (bus_reset_i),
    .wr_valid_i   (wr_valid_i),
    .wr_bit_i     (wr_bit_i),
    .rd_req_i     (rd_req_i),
    .irq_pending_i(irq_pending_i),
    .id_bit_i     (id_bit),
    .idx_o        (idx),
    .rd_bit_o     (rd_bit_o),
    .grant_o      (grant_o)
  );
endmodule

// File: rtl/owrom_slave_chk.sv
module owrom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic wr_valid_i,
  input logic rd_req_i,
  input logic rd_bit_o,
  input logic grant_o,
  input logic ready_i
);
  p_grant_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> rd_bit_o);

  p_reset_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !grant_o);

  p_grant_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !bus_reset_i) |=> grant_o);

  p_init_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> (rd_bit_o && !grant_o));

  p_grant_from_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(wr_valid_i || rd_req_i));
endmodule

bind owrom_slave owrom_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_reset_i(bus_reset_i),
  .wr_valid_i (wr_valid_i),
  .rd_req_i   (rd_req_i),
  .rd_bit_o   (rd_bit_o),
  .grant_o    (grant_o),
  .ready_i    (id_ready)
);

// File: tb/owrom_slave_tb.sv
module owrom_slave_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0]  FAM = 8'h04;
  localparam logic [47:0] SER = 48'h5A_C3_17_E2_90_6B;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_req = 1'b0, irq = 1'b0;
  logic rd_bit, grant;
  int   total = 0, bad = 0;
  logic [63:0] exp_id;

  always #(CLK_P/2) clk = ~clk;

  owrom_slave #(.FAMILY(FAM), .SERIAL(SER)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset), .wr_valid_i(wr_valid),
    .wr_bit_i(wr_bit), .rd_req_i(rd_req), .irq_pending_i(irq),
    .rd_bit_o(rd_bit), .grant_o(grant)
  );

  function automatic logic [7:0] crc_of(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ v[i];
      c = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_rst();
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic wr(input logic b);
    wr_bit = b; wr_valid = 1'b1; @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd(output logic b);
    b = rd_bit; rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  task automatic expect_quiet(input string tag);
    logic b;
    for (int i = 0; i < 3; i++) begin
      rd(b);
      chk(b === 1'b1, tag, b, 1);
    end
    chk(grant === 1'b0, tag, grant, 0);
  endtask

  // R4: match with optional flipped bit (-1 = none)
  task automatic match_run(input int flip);
    bus_rst(); send_cmd(8'h55);
    for (int i = 0; i < 64; i++) wr(exp_id[i] ^ (i == flip));
    chk(grant === (flip < 0), "R4 match grant", grant, flip < 0);
    if (flip >= 0) expect_quiet("R4 dropped after mismatch");
  endtask

  // R5/R6: search; active=0 means device must not take part
  task automatic search_run(input logic [7:0] cmd, input logic active, input int flip, input string tag);
    logic t, c, alive;
    alive = active;
    bus_rst(); send_cmd(cmd);
    for (int i = 0; i < 64; i++) begin
      rd(t); rd(c);
      chk(t === (alive ? exp_id[i] : 1'b1), tag, t, alive ? exp_id[i] : 1'b1);
      chk(c === (alive ? !exp_id[i] : 1'b1), tag, c, alive ? !exp_id[i] : 1'b1);
      wr(exp_id[i] ^ (i == flip));
      if (i == flip) alive = 1'b0;
    end
    chk(grant === alive, {tag, " grant"}, grant, alive);
  endtask

  initial begin
    logic b;
    logic [63:0] got;
    void'($urandom(32'd2024));
    exp_id = {8'h00, SER, FAM};
    exp_id[63:56] = crc_of(exp_id, 56);

    repeat (3) @(negedge clk);
    chk(rd_bit === 1'b1 && grant === 1'b0, "R10 reset state", {rd_bit, grant}, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk);
    bus_rst(); send_cmd(8'hCC);   // R10: ignored during init
    chk(grant === 1'b0 && rd_bit === 1'b1, "R10 init quiet", {rd_bit, grant}, 2'b10);
    repeat (60) @(negedge clk);

    send_cmd(8'hCC);              // R11: no bus reset yet
    chk(grant === 1'b0, "R11 no command before bus reset", grant, 0);

    bus_rst(); send_cmd(8'hCC);
    chk(grant === 1'b1, "R7 skip grant", grant, 1);
    rd(b); chk(b === 1'b1, "R8 release while granted", b, 1);
    bus_rst();
    chk(grant === 1'b0, "R9 bus reset clears grant", grant, 0);

    bus_rst(); send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      rd(b); got[i] = b;
      chk(b === exp_id[i], "R3 read bit", b, exp_id[i]);
    end
    chk(grant === 1'b1, "R3 read grant", grant, 1);
    chk(got[63:56] === crc_of(got, 56), "R1 crc byte", got[63:56], crc_of(got, 56));
    chk(crc_of(got, 64) === 8'h00, "R1 crc residue", crc_of(got, 64), 0);

    bus_rst(); send_cmd(8'h33);   // R9: reset mid-read
    for (int i = 0; i < 10; i++) rd(b);
    bus_rst(); send_cmd(8'hCC);
    chk(grant === 1'b1, "R9 restart after mid-read reset", grant, 1);

    match_run(-1); match_run(0); match_run(63);
    search_run(8'hF0, 1'b1, -1, "R5 search");
    search_run(8'hF0, 1'b1, 0, "R5 search drop");
    search_run(8'hF0, 1'b1, 63, "R5 search drop");
    irq = 1'b1; search_run(8'hEC, 1'b1, -1, "R6 cond search irq");
    irq = 1'b0; search_run(8'hEC, 1'b0, -1, "R6 cond search no irq");

    bus_rst(); send_cmd(8'hA5); expect_quiet("R2 unknown command");
    bus_rst(); send_cmd(8'h0F); expect_quiet("R2 unknown command");

    for (int n = 0; n < 24; n++) begin
      int sel = int'($urandom_range(0, 4));
      int flip = int'($urandom_range(0, 63));
      if ($urandom_range(0, 2) == 0) flip = -1;
      case (sel)
        0: match_run(flip);
        1: search_run(8'hF0, 1'b1, flip, "R5 random search");
        2: begin
          irq = 1'($urandom_range(0, 1));
          search_run(8'hEC, irq, flip, "R6 random cond search");
        end
        3: begin
          logic [7:0] c = 8'($urandom_range(0, 255));
          if (c inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'hEC}) c = 8'h00;
          bus_rst(); send_cmd(c); expect_quiet("R2 random unknown");
        end
        default: begin
          bus_rst(); send_cmd(8'hCC);
          chk(grant === 1'b1, "R7 random skip", grant, 1);
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule